// File: doc/BRIEF.md
# Lockable GPIO Bank Register File

This block is the register front end of a general-purpose I/O controller. It serves up to eight banks of 32 pins. Each pin has a control word whose bit 0 sets its direction. Each bank has four registers:

- a readable output latch;
- a synchronised view of the pad inputs;
- a write-one-to-set port that drives latch bits high;
- a write-one-to-clear port that drives latch bits low.

Software reaches all of this over a plain 32-bit register bus with address, write data, write enable and read data.

Each bank is guarded by a write lock. To change a lock, software first writes a fixed key to a global key register. The very next bus write must then go to that bank's lock register and carry either the lock code or the unlock code. While a bank is locked, writes to its control words and to its set and clear ports are dropped. Reads are never blocked.

Read data is registered. The value for an address presented in one cycle appears on the read-data port after the next rising clock edge.

Top module: `gpio_lockbank_regs`

## Requirements
- R1: After reset every bank is locked, so its lock register reads 0xFFFFFFFF. Every pin is an input, so its control word reads 1 and no output enable is asserted. Every output latch reads 0.
- R2: A write of 0x00A5A501 to the key register at byte offset 0x520, followed on the very next bus write by 0x00000000 to a bank's lock register at 0x500 + 4*bank, unlocks that bank so its lock register reads 0. The same sequence with 0xFFFFFFFF locks it again. Other banks keep their state.
- R3: Several lock-register writes leave the lock state unchanged:
  - a write with no key write immediately before it;
  - a write after the key when another bus write came in between;
  - a write after a key-register write of any value other than 0x00A5A501.
- R4: A lock-register write that follows a valid key but carries a value other than all zeros or all ones leaves the lock state unchanged.
- R5: While a bank is locked, writes to its control words and to its set and clear registers have no effect on direction, output enable or output latch.
- R6: Bit 0 of the control word at 0x100 + 4*pin sets direction: 1 means input, 0 means output. The pin's output enable is high exactly when that bit is 0, and the control word reads back as the bit in position 0 with zeros above.
- R7: Writing the set register at 0x040 + 4*bank makes each latch bit whose data bit is 1 go high. Latch bits whose data bit is 0 keep their value. The latch reads back at 0x000 + 4*bank and drives the output pins.
- R8: Writing the clear register at 0x060 + 4*bank makes each latch bit whose data bit is 1 go low. Latch bits whose data bit is 0 keep their value.
- R9: The input status register at 0x020 + 4*bank returns the bank's 32 pad inputs after they pass through a synchroniser of SYNC_STAGES flops.
- R10: Pin p belongs to bank p>>5 at bit p&31, in both the control-word addressing and the output and enable pin vectors. An unmapped or misaligned address reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| pad_in | input | NUM_BANKS*32 | Pad input levels |
| pad_out | output | NUM_BANKS*32 | Output latch values |
| pad_oe | output | NUM_BANKS*32 | Per-pin output enable |

## Verification
The bench targets the key's one-shot nature in three ways:
- a lock write that follows a dummy write after the key;
- a lock write that follows a near-miss key value;
- a lock write with no key at all.

A design that keeps the key armed too long, or that compares only part of it, would unlock the bank in one of these cases.

It also writes lock codes that are neither all zeros nor all ones. A design that tests only bit 0 of the lock code would change state on these writes.

Writes are aimed at a still-locked bank after another bank has been opened. This exposes gating that uses the wrong bank index.

Pin 37 is checked to land at bank 1, bit 5. Zero-bit set and clear writes are checked to leave the latch alone. An off-by-one in pin decode, or a set or clear port that overwrites the latch instead of merging into it, would fail these checks.

// File: rtl/gpio_lock_pkg.sv
package gpio_lock_pkg;
  localparam int unsigned MAX_BANKS  = 8;
  localparam int unsigned BANK_PINS  = 32;
  localparam int unsigned BANK_W     = 3;
  localparam int unsigned BIT_W      = 5;
  localparam int unsigned WORD_W     = 10;
  localparam logic [31:0] KEY_VALUE  = 32'h00A5A501;
  localparam logic [31:0] CODE_LOCK  = 32'hFFFFFFFF;
  localparam logic [31:0] CODE_OPEN  = 32'h00000000;

  // word-address region bases (byte offset / 4)
  localparam logic [WORD_W-1:0] W_OUT  = 10'd0;
  localparam logic [WORD_W-1:0] W_IN   = 10'd8;
  localparam logic [WORD_W-1:0] W_SET  = 10'd16;
  localparam logic [WORD_W-1:0] W_CLR  = 10'd24;
  localparam logic [WORD_W-1:0] W_CTRL = 10'd64;
  localparam logic [WORD_W-1:0] W_LOCK = 10'd320;
  localparam logic [WORD_W-1:0] W_KEY  = 10'd328;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_OUT,
    RK_IN,
    RK_SET,
    RK_CLR,
    RK_CTRL,
    RK_LOCK,
    RK_KEY
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e         kind;
    logic [BANK_W-1:0] bank;
    logic [BIT_W-1:0]  bit_idx;
  } reg_sel_t;
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_lock_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8
) (
  input  logic [11:0] bus_addr,
  output reg_sel_t    sel
);
  localparam int unsigned NUM_PINS = NUM_BANKS * BANK_PINS;

  logic [WORD_W-1:0] waddr;
  logic [WORD_W-1:0] pin_off;
  logic [WORD_W-1:0] bank_off;
  logic              aligned;

  assign waddr   = bus_addr[11:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign pin_off = waddr - W_CTRL;

  always_comb begin
    sel      = '0;
    sel.kind = RK_NONE;
    bank_off = '0;
    if (aligned) begin
      if (waddr < W_CTRL) begin
        bank_off = {7'd0, waddr[2:0]};
        if (32'(bank_off) < NUM_BANKS) begin
          sel.bank = waddr[2:0];
          unique case (waddr[4:3])
            2'd0: sel.kind = RK_OUT;
            2'd1: sel.kind = RK_IN;
            2'd2: sel.kind = RK_SET;
            default: sel.kind = RK_CLR;
          endcase
          if (waddr[WORD_W-1:5] != '0) sel.kind = RK_NONE;
        end
      end else if (waddr < W_LOCK) begin
        if (32'(pin_off) < NUM_PINS) begin
          sel.kind    = RK_CTRL;
          sel.bank    = pin_off[7:5];
          sel.bit_idx = pin_off[4:0];
        end
      end else if (waddr < W_KEY) begin
        bank_off = waddr - W_LOCK;
        if (32'(bank_off) < NUM_BANKS) begin
          sel.kind = RK_LOCK;
          sel.bank = bank_off[BANK_W-1:0];
        end
      end else if (waddr == W_KEY) begin
        sel.kind = RK_KEY;
      end
    end
  end
endmodule

// File: rtl/gpio_key_lock.sv
module gpio_key_lock
  import gpio_lock_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_we,
  input  logic [31:0]          bus_wdata,
  input  reg_sel_t             sel,
  output logic [NUM_BANKS-1:0] locked
);
  logic                 armed_q, armed_d;
  logic [NUM_BANKS-1:0] lock_q, lock_d;

  // key arms only the single next write
  always_comb begin
    armed_d = armed_q;
    if (bus_we) armed_d = (sel.kind == RK_KEY) && (bus_wdata == KEY_VALUE);
  end

  always_comb begin
    lock_d = lock_q;
    if (bus_we && armed_q && sel.kind == RK_LOCK) begin
      for (int b = 0; b < int'(NUM_BANKS); b++) begin
        if (32'(sel.bank) == b) begin
          if (bus_wdata == CODE_LOCK) lock_d[b] = 1'b1;
          else if (bus_wdata == CODE_OPEN) lock_d[b] = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      lock_q  <= '1;
    end else begin
      armed_q <= armed_d;
      lock_q  <= lock_d;
    end
  end

  assign locked = lock_q;

  // R3: a non-key write always leaves the key disarmed
  p_key_one_shot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && bus_we && sel.kind != RK_KEY) |=> !armed_q);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_lock_chk
    // R3: a lock bit changes only after an armed cycle
    p_change_needs_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q[b] != $past(lock_q[b])) |-> $past(armed_q));
    // R4: unlocking only by the all-zero code
    p_open_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lock_q[b]) |-> ($past(bus_wdata) == CODE_OPEN));
    // R4: locking only by the all-ones code
    p_lock_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_q[b]) |-> ($past(bus_wdata) == CODE_LOCK));
  end
endmodule

// File: rtl/gpio_pin_bank.sv
module gpio_pin_bank
  import gpio_lock_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 locked,
  input  logic                 ctrl_we,
  input  logic [BIT_W-1:0]     ctrl_idx,
  input  logic                 ctrl_dir,
  input  logic                 set_we,
  input  logic                 clr_we,
  input  logic [BANK_PINS-1:0] wmask,
  input  logic [BANK_PINS-1:0] pad_in,
  output logic [BANK_PINS-1:0] out_q,
  output logic [BANK_PINS-1:0] dir_q,
  output logic [BANK_PINS-1:0] in_sync,
  output logic [BANK_PINS-1:0] pad_oe
);
  logic [BANK_PINS-1:0] out_d, dir_d;
  logic                 wr_ok;
  logic [BANK_PINS-1:0] sync_q [SYNC_STAGES];

  assign wr_ok = !locked;

  always_comb begin
    out_d = out_q;
    dir_d = dir_q;
    if (wr_ok && set_we) out_d = out_q | wmask;
    if (wr_ok && clr_we) out_d = out_q & ~wmask;
    if (wr_ok && ctrl_we) dir_d[ctrl_idx] = ctrl_dir;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '1;
    end else begin
      out_q <= out_d;
      dir_q <= dir_d;
    end
  end

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[s] <= '0;
      else if (s == 0) sync_q[s] <= pad_in;
      else sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
    end
  end

  assign in_sync = sync_q[SYNC_STAGES-1];
  assign pad_oe  = ~dir_q;

  // R5: a locked bank keeps its latch and directions
  p_locked_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> ($stable(out_q) && $stable(dir_q)));
  // R7: set bits are high after an accepted set write
  p_set_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && !locked) |=> ((out_q & $past(wmask)) == $past(wmask)));
  // R8: clear bits are low after an accepted clear write
  p_clr_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !locked) |=> ((out_q & $past(wmask)) == '0));
endmodule

// File: rtl/gpio_lockbank_regs.sv
module gpio_lockbank_regs
  import gpio_lock_pkg::*;
#(
  parameter int unsigned NUM_BANKS   = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [11:0]                    bus_addr,
  input  logic [31:0]                    bus_wdata,
  input  logic                           bus_we,
  output logic [31:0]                    bus_rdata,
  input  logic [NUM_BANKS*BANK_PINS-1:0] pad_in,
  output logic [NUM_BANKS*BANK_PINS-1:0] pad_out,
  output logic [NUM_BANKS*BANK_PINS-1:0] pad_oe
);
  reg_sel_t             sel;
  logic [NUM_BANKS-1:0] locked;
  logic [BANK_PINS-1:0] bk_out [NUM_BANKS];
  logic [BANK_PINS-1:0] bk_dir [NUM_BANKS];
  logic [BANK_PINS-1:0] bk_in  [NUM_BANKS];
  logic [31:0]          rd_d, rd_q;

  gpio_addr_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
    .bus_addr (bus_addr),
    .sel      (sel)
  );

  gpio_key_lock #(.NUM_BANKS(NUM_BANKS)) u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .sel       (sel),
    .locked    (locked)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (32'(sel.bank) == b);
    gpio_pin_bank #(.SYNC_STAGES(SYNC_STAGES)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .locked   (locked[b]),
      .ctrl_we  (bus_we && hit && sel.kind == RK_CTRL),
      .ctrl_idx (sel.bit_idx),
      .ctrl_dir (bus_wdata[0]),
      .set_we   (bus_we && hit && sel.kind == RK_SET),
      .clr_we   (bus_we && hit && sel.kind == RK_CLR),
      .wmask    (bus_wdata),
      .pad_in   (pad_in[b*BANK_PINS +: BANK_PINS]),
      .out_q    (bk_out[b]),
      .dir_q    (bk_dir[b]),
      .in_sync  (bk_in[b]),
      .pad_oe   (pad_oe[b*BANK_PINS +: BANK_PINS])
    );
    assign pad_out[b*BANK_PINS +: BANK_PINS] = bk_out[b];
  end

  always_comb begin
    rd_d = '0;
    unique case (sel.kind)
      RK_OUT:  rd_d = bk_out[sel.bank];
      RK_IN:   rd_d = bk_in[sel.bank];
      RK_CTRL: rd_d = {31'd0, bk_dir[sel.bank][sel.bit_idx]};
      RK_LOCK: rd_d = {32{locked[sel.bank]}};
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign bus_rdata = rd_q;

  // R10: unmapped addresses read back as zero
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel.kind == RK_NONE) |=> (bus_rdata == '0));
endmodule

// File: tb/gpio_lockbank_regs_tb.sv
module gpio_lockbank_regs_tb;
  localparam int NB = 8;
  localparam int NP = NB * 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        rd_fire = 1'b0;
  logic        rd_fire_d = 1'b0;

  always #2.5 clk = ~clk;

  gpio_lockbank_regs #(.NUM_BANKS(NB), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  always @(posedge clk) rd_fire_d <= rd_fire;

  // monitor: compare registered read data against the scoreboard
  always @(negedge clk) begin
    if (rd_fire_d && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (bus_rdata !== e) begin
        n_bad++;
        $display("FAIL %s: read act=%h exp=%h", t, bus_rdata, e);
      end
    end
  end

  function automatic logic [11:0] a_out(int b);  return 12'(b*4); endfunction
  function automatic logic [11:0] a_in(int b);   return 12'(32'h20 + b*4); endfunction
  function automatic logic [11:0] a_set(int b);  return 12'(32'h40 + b*4); endfunction
  function automatic logic [11:0] a_clr(int b);  return 12'(32'h60 + b*4); endfunction
  function automatic logic [11:0] a_ctl(int p);  return 12'(32'h100 + p*4); endfunction
  function automatic logic [11:0] a_lck(int b);  return 12'(32'h500 + b*4); endfunction
  localparam logic [11:0] A_KEY = 12'h520;
  localparam logic [31:0] KEY = 32'h00A5A501;

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1; rd_fire = 1'b0;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    exp_q.push_back(e); tag_q.push_back(t);
    rd_fire = 1'b1;
    @(negedge clk);
    rd_fire = 1'b0;
  endtask

  task automatic chk(input string t, input logic [NP-1:0] act, input logic [NP-1:0] e);
    n_chk++;
    if (act !== e) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", t, act, e);
    end
  endtask

  task automatic open_bank(input int b);
    wr(A_KEY, KEY);
    wr(a_lck(b), 32'h0);
  endtask

  logic [NP-1:0] exp_oe;
  logic [NP-1:0] exp_out;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 oe", pad_oe, '0);
    chk("R1 out", pad_out, '0);
    rd(a_lck(0), 32'hFFFFFFFF, "R1 lock0");
    rd(a_lck(7), 32'hFFFFFFFF, "R1 lock7");
    rd(a_ctl(0), 32'h1, "R1 ctrl0");
    rd(a_out(0), 32'h0, "R1 out0");

    // R5 writes to locked bank dropped
    wr(a_ctl(0), 32'h0);
    wr(a_set(0), 32'h0000FFFF);
    chk("R5 oe", pad_oe, '0);
    chk("R5 out", pad_out, '0);
    rd(a_ctl(0), 32'h1, "R5 ctrl0");

    // R3 key sequencing
    wr(a_lck(0), 32'h0);
    rd(a_lck(0), 32'hFFFFFFFF, "R3 no key");
    wr(A_KEY, KEY);
    wr(a_out(0), 32'h0);
    wr(a_lck(0), 32'h0);
    rd(a_lck(0), 32'hFFFFFFFF, "R3 intervening write");
    wr(A_KEY, 32'h00A5A500);
    wr(a_lck(0), 32'h0);
    rd(a_lck(0), 32'hFFFFFFFF, "R3 wrong key");

    // R2 unlock bank 0 only
    open_bank(0);
    rd(a_lck(0), 32'h0, "R2 bank0 open");
    rd(a_lck(1), 32'hFFFFFFFF, "R2 bank1 still locked");

    // R4 bad lock codes
    wr(A_KEY, KEY);
    wr(a_lck(0), 32'h12345678);
    rd(a_lck(0), 32'h0, "R4 bank0 stays open");
    wr(A_KEY, KEY);
    wr(a_lck(1), 32'h00000001);
    rd(a_lck(1), 32'hFFFFFFFF, "R4 bank1 stays locked");

    // R6 direction and output enable
    wr(a_ctl(3), 32'hFFFFFFFE);
    exp_oe = '0; exp_oe[3] = 1'b1;
    chk("R6 oe pin3", pad_oe, exp_oe);
    rd(a_ctl(3), 32'h0, "R6 ctrl3");
    wr(a_ctl(4), 32'h0);
    wr(a_ctl(4), 32'h1);
    chk("R6 pin4 back to input", pad_oe, exp_oe);

    // R7 set
    wr(a_set(0), 32'h000000F0);
    exp_out = '0; exp_out[31:0] = 32'hF0;
    chk("R7 set F0", pad_out, exp_out);
    wr(a_set(0), 32'h0);
    chk("R7 zero set", pad_out, exp_out);
    wr(a_set(0), 32'h3);
    exp_out[31:0] = 32'hF3;
    chk("R7 merge", pad_out, exp_out);
    rd(a_out(0), 32'hF3, "R7 readback");

    // R8 clear
    wr(a_clr(0), 32'h30);
    exp_out[31:0] = 32'hC3;
    chk("R8 clear", pad_out, exp_out);
    wr(a_clr(0), 32'h0);
    chk("R8 zero clear", pad_out, exp_out);
    rd(a_out(0), 32'hC3, "R8 readback");

    // R5 bank1 still locked while bank0 open
    wr(a_set(1), 32'hFFFFFFFF);
    chk("R5 bank1 set dropped", pad_out, exp_out);

    // R10 pin mapping: pin 37 -> bank1 bit5
    open_bank(1);
    wr(a_ctl(37), 32'h0);
    exp_oe[37] = 1'b1;
    chk("R10 oe pin37", pad_oe, exp_oe);
    wr(a_set(1), 32'h20);
    exp_out[37] = 1'b1;
    chk("R10 out pin37", pad_out, exp_out);
    rd(a_out(1), 32'h20, "R10 out1");
    rd(12'h600, 32'h0, "R10 unmapped");
    rd(12'h501, 32'h0, "R10 misaligned");

    // R9 input synchronisation
    @(negedge clk);
    pad_in = '0;
    pad_in[31:0]    = 32'hDEADBEEF;
    pad_in[191:160] = 32'h13572468;
    repeat (4) @(negedge clk);
    rd(a_in(0), 32'hDEADBEEF, "R9 in0");
    rd(a_in(5), 32'h13572468, "R9 in5");

    // R2 relock bank0, R5 then blocks clear
    wr(A_KEY, KEY);
    wr(a_lck(0), 32'hFFFFFFFF);
    rd(a_lck(0), 32'hFFFFFFFF, "R2 relock");
    wr(a_clr(0), 32'hFF);
    chk("R5 relocked clear dropped", pad_out, exp_out);

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule